// File: doc/BRIEF.md
# Debug Run-Control Register Block

This block is the run-control corner of a hardware debug module for a single hart. A debugger-side register bus (7-bit address, 32-bit data, separate read and write strobes) reaches two registers: a control word the host writes to steer the hart, and a read-only status word that reports what the hart is doing. From the control word the block drives level request lines towards the hart: halt, resume and a per-hart reset. It also drives a reset line for the rest of the system.

The hart reports back through three plain inputs: halted, running, and a reset-done indication. The block turns these into status flags. Two of the flags are sticky, so the host can poll at its own pace. The resume acknowledge records that the hart left the halted state after a resume request. The have-reset flag records that a reset finished, and it stays set until the host acknowledges it.

A build without per-hart reset reads that control bit back as zero, which tells the host to fall back to the system reset. The bus has no back-pressure: every strobe is accepted in the cycle it is seen. Read data comes back exactly one cycle after the read strobe, marked by a valid pulse.

Top module: `dmrc_top`

## Requirements
- R1: After reset every request output is 0, the control word reads 0x00000000, and with all hart inputs low the status word reads 0x000000A2 when reset-halt support is built in and 0x00000082 when it is not.
- R2: Control bit 0 is the module-active bit. A control write with bit 0 clear returns every control field, the reset-halt arming and both sticky flags to 0. While the active bit is 0, no request output is asserted.
- R3: A control write with bits 0 and 31 set raises hart_halt_req_o from the next cycle. The request holds until a control write clears bit 31, and bit 31 reads back the request.
- R4: Control bit 30 drives hart_resume_req_o. The resume-ack flag (status bits 17 and 16) clears on any control write with bit 30 set. It sets only in the cycle after the hart's halted input falls while its running input is high. After that it holds through writes that leave bit 30 clear.
- R5: Control bit 29 drives hart_reset_o and reads back when per-hart reset is built in. Without it, bit 29 reads 0 and hart_reset_o never rises.
- R6: Control bit 1 drives sys_reset_o and reads back. The reset is released by writing the bit low again.
- R7: The have-reset flag (status bits 19 and 18) sets when hart_reset_done_i is high while the module is active. It clears on a control write with bit 28 set. If both happen in the same cycle, the set wins.
- R8: Control bit 3 arms halt-on-reset and bit 2 disarms it, with disarm winning when both are set. While armed and either reset output is high, hart_halt_req_o is high. Status bit 5 reports whether this feature is built in; without it, bit 3 has no effect.
- R9: With hart select 0, status bits 9/8 follow the halted input and bits 11/10 follow the running input. Have-reset and halted can both read 1 at once.
- R10: Control bits 25:16 and 15:6 hold the two halves of hart select and read back. A nonzero select reads status bits 15/14 (nonexistent) as 1 and bits 19:16 and 11:8 as 0. Bits 13/12 (unavailable) always read 0.
- R11: The status word always shows version 2 in bits 3:0 and authenticated (bit 7) as 1. Bits 6 and 4 read 0, and bit 22 shows the implicit-breakpoint parameter.
- R12: bus_rvalid_o pulses exactly one cycle after bus_rd_i, carrying the word addressed in the strobe cycle. Unmapped addresses read 0. Writes to the status address or to unmapped addresses change nothing. Control bits 28, 26, 3 and 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 7 | Register address (control 0x10, status 0x11) |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after bus_rd_i |
| bus_rdata_o | output | 32 | Read data |
| hart_halted_i | input | 1 | Hart is halted |
| hart_running_i | input | 1 | Hart is running |
| hart_reset_done_i | input | 1 | Hart has come out of a reset |
| hart_halt_req_o | output | 1 | Halt request to the hart |
| hart_resume_req_o | output | 1 | Resume request to the hart |
| hart_reset_o | output | 1 | Per-hart reset |
| sys_reset_o | output | 1 | System reset outside the debug module |

## Verification
Some rules are checked by assertions on every cycle. These are: request silence while inactive, the halt and system-reset lines following their control writes, and the resume-ack flag rising only after a halted-to-running edge. Also checked each cycle are the set and clear priority of the have-reset flag and the one-cycle read latency. Other behaviour only shows up in the bench scenarios, which compare the read-back words against values built arithmetically. Those scenarios cover the full control-bit sweep with its masked fields, the status word across hart-select and hart-state combinations, and the per-hart reset fallback in the reduced build. They also cover halt-on-reset arming carried across many writes, and a halt held through a reset.

// File: rtl/dmrc_pkg.sv
package dmrc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SEL_W  = 10;

  // control word bit positions (the host decodes these)
  localparam int unsigned C_HALT    = 31;
  localparam int unsigned C_RESUME  = 30;
  localparam int unsigned C_HRESET  = 29;
  localparam int unsigned C_ACKRST  = 28;
  localparam int unsigned C_SELLO   = 16;
  localparam int unsigned C_SELHI   = 6;
  localparam int unsigned C_RHR_SET = 3;
  localparam int unsigned C_RHR_CLR = 2;
  localparam int unsigned C_SYSRST  = 1;
  localparam int unsigned C_ACTIVE  = 0;

  // status word bit positions (all flag sits one above its any flag)
  localparam int unsigned S_IMPEB   = 22;
  localparam int unsigned S_HAVERST = 18;
  localparam int unsigned S_RACK    = 16;
  localparam int unsigned S_NONEX   = 14;
  localparam int unsigned S_UNAV    = 12;
  localparam int unsigned S_RUN     = 10;
  localparam int unsigned S_HALT    = 8;
  localparam int unsigned S_AUTH    = 7;
  localparam int unsigned S_HASRHR  = 5;
  localparam logic [3:0]  VERSION   = 4'd2;

  typedef struct packed {
    logic                 active;
    logic                 halt;
    logic                 resume;
    logic                 sysrst;
    logic [2*SEL_W-1:0]   hartsel;  // {high half, low half}
  } ctrl_t;
endpackage

// File: rtl/dmrc_ctrl.sv
module dmrc_ctrl
  import dmrc_pkg::*;
#(
  parameter bit HAS_HART_RESET = 1'b1,
  parameter bit HAS_RESET_HALT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic              hreset_o,
  output logic              rhr_o,
  output logic              ack_rst_o,
  output logic              resume_wr_o
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  load_en;
  logic  unused_wbits;

  assign load_en = wr_i & wdata_i[C_ACTIVE];
  assign unused_wbits = ^{wdata_i[27:26], wdata_i[5:4]};

  always_comb begin
    ctrl_d         = '0;
    ctrl_d.active  = 1'b1;
    ctrl_d.halt    = wdata_i[C_HALT];
    ctrl_d.resume  = wdata_i[C_RESUME];
    ctrl_d.sysrst  = wdata_i[C_SYSRST];
    ctrl_d.hartsel = {wdata_i[C_SELHI +: SEL_W], wdata_i[C_SELLO +: SEL_W]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctrl_q <= '0;
    else if (wr_i)   ctrl_q <= load_en ? ctrl_d : '0;
  end

  generate
    if (HAS_HART_RESET) begin : g_hreset
      logic hreset_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   hreset_q <= 1'b0;
        else if (wr_i) hreset_q <= load_en & wdata_i[C_HRESET];
      end
      assign hreset_o = hreset_q;
    end else begin : g_no_hreset
      assign hreset_o = 1'b0;
    end

    if (HAS_RESET_HALT) begin : g_rhr
      logic rhr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rhr_q <= 1'b0;
        else if (wr_i) begin
          if (!load_en)                    rhr_q <= 1'b0;
          else if (wdata_i[C_RHR_CLR])     rhr_q <= 1'b0;
          else if (wdata_i[C_RHR_SET])     rhr_q <= 1'b1;
        end
      end
      assign rhr_o = rhr_q;
    end else begin : g_no_rhr
      assign rhr_o = 1'b0;
    end
  endgenerate

  assign ctrl_o      = ctrl_q;
  assign ack_rst_o   = load_en & wdata_i[C_ACKRST];
  assign resume_wr_o = load_en & wdata_i[C_RESUME];
endmodule

// File: rtl/dmrc_sticky.sv
module dmrc_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic resume_wr_i,
  input  logic ack_rst_i,
  input  logic halted_i,
  input  logic running_i,
  input  logic reset_done_i,
  output logic havereset_o,
  output logic resumeack_o
);
  logic prev_halted_q;
  logic havereset_q;
  logic resumeack_q;
  logic left_halt;

  assign left_halt = prev_halted_q & ~halted_i & running_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_halted_q <= 1'b0;
    else         prev_halted_q <= halted_i;
  end

  // set has priority over the acknowledge so a fresh reset is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           havereset_q <= 1'b0;
    else if (!active_i)    havereset_q <= 1'b0;
    else if (reset_done_i) havereset_q <= 1'b1;
    else if (ack_rst_i)    havereset_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          resumeack_q <= 1'b0;
    else if (!active_i)   resumeack_q <= 1'b0;
    else if (left_halt)   resumeack_q <= 1'b1;
    else if (resume_wr_i) resumeack_q <= 1'b0;
  end

  assign havereset_o = havereset_q;
  assign resumeack_o = resumeack_q;
endmodule

// File: rtl/dmrc_status.sv
module dmrc_status
  import dmrc_pkg::*;
#(
  parameter bit HAS_RESET_HALT = 1'b1,
  parameter bit IMPEBREAK      = 1'b0
) (
  input  ctrl_t             ctrl_i,
  input  logic              hreset_i,
  input  logic              havereset_i,
  input  logic              resumeack_i,
  input  logic              halted_i,
  input  logic              running_i,
  output logic [WORD_W-1:0] ctrl_word_o,
  output logic [WORD_W-1:0] stat_word_o
);
  logic selected;

  assign selected = (ctrl_i.hartsel == '0);

  always_comb begin
    ctrl_word_o                    = '0;
    ctrl_word_o[C_HALT]            = ctrl_i.halt;
    ctrl_word_o[C_RESUME]          = ctrl_i.resume;
    ctrl_word_o[C_HRESET]          = hreset_i;
    ctrl_word_o[C_SELLO +: SEL_W]  = ctrl_i.hartsel[SEL_W-1:0];
    ctrl_word_o[C_SELHI +: SEL_W]  = ctrl_i.hartsel[2*SEL_W-1:SEL_W];
    ctrl_word_o[C_SYSRST]          = ctrl_i.sysrst;
    ctrl_word_o[C_ACTIVE]          = ctrl_i.active;
  end

  always_comb begin
    stat_word_o                  = '0;
    stat_word_o[3:0]             = VERSION;
    stat_word_o[S_AUTH]          = 1'b1;
    stat_word_o[S_HASRHR]        = HAS_RESET_HALT;
    stat_word_o[S_IMPEB]         = IMPEBREAK;
    if (selected) begin
      stat_word_o[S_HAVERST +: 2] = {2{havereset_i}};
      stat_word_o[S_RACK +: 2]    = {2{resumeack_i}};
      stat_word_o[S_RUN +: 2]     = {2{running_i}};
      stat_word_o[S_HALT +: 2]    = {2{halted_i}};
    end else begin
      stat_word_o[S_NONEX +: 2]   = 2'b11;
    end
  end
endmodule

// File: rtl/dmrc_top.sv
module dmrc_top
  import dmrc_pkg::*;
#(
  parameter int unsigned       ADDR_W         = 7,
  parameter logic [ADDR_W-1:0] CTRL_ADDR      = 7'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR      = 7'h11,
  parameter bit                HAS_HART_RESET = 1'b1,
  parameter bit                HAS_RESET_HALT = 1'b1,
  parameter bit                IMPEBREAK      = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic              bus_rvalid_o,
  output logic [31:0]       bus_rdata_o,
  input  logic              hart_halted_i,
  input  logic              hart_running_i,
  input  logic              hart_reset_done_i,
  output logic              hart_halt_req_o,
  output logic              hart_resume_req_o,
  output logic              hart_reset_o,
  output logic              sys_reset_o
);
  ctrl_t             ctrl;
  logic              hreset;
  logic              rhr;
  logic              ack_rst;
  logic              resume_wr;
  logic              havereset;
  logic              resumeack;
  logic              ctrl_active;
  logic              wr_ctrl;
  logic [WORD_W-1:0] ctrl_word;
  logic [WORD_W-1:0] stat_word;
  logic [WORD_W-1:0] rd_mux;
  logic              rvalid_q;
  logic [WORD_W-1:0] rdata_q;

  assign wr_ctrl     = bus_wr_i && (bus_addr_i == CTRL_ADDR);
  assign ctrl_active = ctrl.active;

  dmrc_ctrl #(
    .HAS_HART_RESET (HAS_HART_RESET),
    .HAS_RESET_HALT (HAS_RESET_HALT)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_ctrl),
    .wdata_i     (bus_wdata_i),
    .ctrl_o      (ctrl),
    .hreset_o    (hreset),
    .rhr_o       (rhr),
    .ack_rst_o   (ack_rst),
    .resume_wr_o (resume_wr)
  );

  dmrc_sticky u_sticky (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_i     (ctrl_active),
    .resume_wr_i  (resume_wr),
    .ack_rst_i    (ack_rst),
    .halted_i     (hart_halted_i),
    .running_i    (hart_running_i),
    .reset_done_i (hart_reset_done_i),
    .havereset_o  (havereset),
    .resumeack_o  (resumeack)
  );

  dmrc_status #(
    .HAS_RESET_HALT (HAS_RESET_HALT),
    .IMPEBREAK      (IMPEBREAK)
  ) u_status (
    .ctrl_i      (ctrl),
    .hreset_i    (hreset),
    .havereset_i (havereset),
    .resumeack_i (resumeack),
    .halted_i    (hart_halted_i),
    .running_i   (hart_running_i),
    .ctrl_word_o (ctrl_word),
    .stat_word_o (stat_word)
  );

  always_comb begin
    if (bus_addr_i == CTRL_ADDR)      rd_mux = ctrl_word;
    else if (bus_addr_i == STAT_ADDR) rd_mux = stat_word;
    else                              rd_mux = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= bus_rd_i;
      if (bus_rd_i) rdata_q <= rd_mux;
    end
  end

  assign bus_rvalid_o      = rvalid_q;
  assign bus_rdata_o       = rdata_q;
  assign hart_halt_req_o   = ctrl.halt | (rhr & (hreset | ctrl.sysrst));
  assign hart_resume_req_o = ctrl.resume;
  assign hart_reset_o      = hreset;
  assign sys_reset_o       = ctrl.sysrst;
endmodule

// File: rtl/dmrc_checker.sv
module dmrc_checker #(
  parameter int unsigned       ADDR_W    = 7,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic              bus_rvalid_o,
  input logic              hart_halted_i,
  input logic              hart_running_i,
  input logic              hart_reset_done_i,
  input logic              hart_halt_req_o,
  input logic              hart_resume_req_o,
  input logic              hart_reset_o,
  input logic              sys_reset_o,
  input logic              active_i,
  input logic              havereset_i,
  input logic              resumeack_i
);
  logic wr_ctrl;
  assign wr_ctrl = bus_wr_i && (bus_addr_i == CTRL_ADDR);

  // R2
  inactive_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !(hart_halt_req_o || hart_resume_req_o || hart_reset_o || sys_reset_o));

  // R3
  halt_follows_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && bus_wdata_i[0] && bus_wdata_i[31]) |=> hart_halt_req_o);

  // R6
  sysrst_follows_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (sys_reset_o == ($past(bus_wdata_i[0]) && $past(bus_wdata_i[1]))));

  // R4
  ack_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resumeack_i) |-> ($past(hart_running_i) && !$past(hart_halted_i) && $past(hart_halted_i, 2)));

  // R7
  havereset_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hart_reset_done_i && active_i) |=> havereset_i);

  // R7
  havereset_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && bus_wdata_i[0] && bus_wdata_i[28] && !hart_reset_done_i) |=> !havereset_i);

  // R12
  rvalid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i |=> bus_rvalid_o);

  // R12
  rvalid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> !bus_rvalid_o);
endmodule

bind dmrc_top dmrc_checker #(
  .ADDR_W    (ADDR_W),
  .CTRL_ADDR (CTRL_ADDR)
) u_dmrc_checker (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .bus_wr_i          (bus_wr_i),
  .bus_rd_i          (bus_rd_i),
  .bus_addr_i        (bus_addr_i),
  .bus_wdata_i       (bus_wdata_i),
  .bus_rvalid_o      (bus_rvalid_o),
  .hart_halted_i     (hart_halted_i),
  .hart_running_i    (hart_running_i),
  .hart_reset_done_i (hart_reset_done_i),
  .hart_halt_req_o   (hart_halt_req_o),
  .hart_resume_req_o (hart_resume_req_o),
  .hart_reset_o      (hart_reset_o),
  .sys_reset_o       (sys_reset_o),
  .active_i          (ctrl_active),
  .havereset_i       (havereset),
  .resumeack_i       (resumeack)
);

// File: tb/dmrc_top_bench.sv
`timescale 1ns/100ps
module dmrc_top_bench;
  localparam logic [6:0]  CA = 7'h10;
  localparam logic [6:0]  SA = 7'h11;
  localparam logic [31:0] MASK_FULL = 32'hE3FF_FFC3;
  localparam logic [31:0] MASK_NOHR = 32'hC3FF_FFC3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        halted = 1'b0, running = 1'b0, rdone = 1'b0;
  logic        rv0, rv1, hq0, hq1, rq0, rq1, hr0, hr1, sr0, sr1;
  logic [31:0] rd0, rd1;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dmrc_top u_dmrc_top (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rvalid_o(rv0), .bus_rdata_o(rd0),
    .hart_halted_i(halted), .hart_running_i(running), .hart_reset_done_i(rdone),
    .hart_halt_req_o(hq0), .hart_resume_req_o(rq0), .hart_reset_o(hr0), .sys_reset_o(sr0));

  dmrc_top #(.HAS_HART_RESET(1'b0), .HAS_RESET_HALT(1'b0)) u_dmrc_top_nohr (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rvalid_o(rv1), .bus_rdata_o(rd1),
    .hart_halted_i(halted), .hart_running_i(running), .hart_reset_done_i(rdone),
    .hart_halt_req_o(hq1), .hart_resume_req_o(rq1), .hart_reset_o(hr1), .sys_reset_o(sr1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d0, output logic [31:0] d1);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    chk("R12 rvalid", {30'd0, rv1, rv0}, 32'd3);
    d0 = rd0; d1 = rd1;
    @(negedge clk);
    chk("R12 rvalid drop", {30'd0, rv1, rv0}, 32'd0);
  endtask

  function automatic logic [31:0] exp_stat(bit h, bit r, bit hv, bit ra, bit nz, bit rhr_sup);
    logic [31:0] s;
    s = 32'h0000_0082 | (32'(rhr_sup) << 5);
    if (nz) s |= 32'h0000_C000;
    else begin
      if (hv) s |= 32'h000C_0000;
      if (ra) s |= 32'h0003_0000;
      if (r)  s |= 32'h0000_0C00;
      if (h)  s |= 32'h0000_0300;
    end
    return s;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a0, a1;
    bit armed, exp_ack, prev_h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 outputs", {28'd0, hq0, rq0, hr0, sr0}, 32'd0);
    rd(CA, a0, a1); chk("R1 ctrl", a0, 32'd0); chk("R1 ctrl nohr", a1, 32'd0);
    rd(SA, a0, a1); chk("R1 R11 status", a0, 32'h0000_00A2); chk("R1 R11 status nohr", a1, 32'h0000_0082);

    // R2 write without active bit is dropped
    wr(CA, 32'hFFFF_FFFE);
    chk("R2 outputs", {28'd0, hq0, rq0, hr0, sr0}, 32'd0);
    rd(CA, a0, a1); chk("R2 ctrl", a0, 32'd0);

    // single-bit sweep of the control word (R3 R5 R6 R8 R10 R12)
    armed = 1'b0;
    for (int i = 0; i < 32; i++) begin
      logic [31:0] w;
      w = (32'd1 << i) | 32'd1;
      wr(CA, w);
      if (w[2]) armed = 1'b0; else if (w[3]) armed = 1'b1;
      chk("R3 R8 halt line", {31'd0, hq0}, {31'd0, (i == 31) | (armed & ((i == 29) | (i == 1)))});
      chk("R3 halt line nohr", {31'd0, hq1}, {31'd0, i == 31});
      chk("R4 resume line", {30'd0, rq1, rq0}, {30'd0, {2{i == 30}}});
      chk("R5 hart reset lines", {30'd0, hr1, hr0}, {31'd0, i == 29});
      chk("R6 sys reset lines", {30'd0, sr1, sr0}, {30'd0, {2{i == 1}}});
      rd(CA, a0, a1);
      chk("R10 R12 ctrl readback", a0, w & MASK_FULL);
      chk("R5 ctrl readback nohr", a1, w & MASK_NOHR);
    end
    wr(CA, 32'h5);

    // status sweep over hart select and hart state (R9 R10 R4)
    exp_ack = 1'b0; prev_h = 1'b0;
    for (int s = 0; s < 3; s++) begin
      for (int c = 0; c < 4; c++) begin
        logic [31:0] sel;
        sel = (s == 0) ? 32'd0 : (s == 1) ? 32'h0000_0040 : 32'h0001_0000;
        @(negedge clk); halted = c[0]; running = c[1];
        if (prev_h && !halted && running) exp_ack = 1'b1;
        prev_h = halted;
        wr(CA, sel | 32'd1);
        rd(SA, a0, a1);
        chk("R9 R10 status", a0, exp_stat(halted, running, 1'b0, exp_ack, s != 0, 1'b1));
        chk("R9 R10 status nohr", a1, exp_stat(halted, running, 1'b0, exp_ack, s != 0, 1'b0));
      end
    end

    // R3 halt handshake
    @(negedge clk); halted = 1'b0; running = 1'b1;
    wr(CA, 32'h8000_0001);
    chk("R3 halt req", {31'd0, hq0}, 32'd1);
    @(negedge clk); halted = 1'b1; running = 1'b0;
    rd(SA, a0, a1); chk("R3 R9 halted", a0 & 32'h0000_0F00, 32'h0000_0300);
    wr(CA, 32'h1);
    chk("R3 halt released", {31'd0, hq0}, 32'd0);

    // R4 resume handshake
    wr(CA, 32'h4000_0001);
    chk("R4 resume req", {31'd0, rq0}, 32'd1);
    rd(SA, a0, a1); chk("R4 ack cleared", a0 & 32'h0003_0000, 32'd0);
    @(negedge clk); halted = 1'b0; running = 1'b1;
    @(negedge clk);
    rd(SA, a0, a1); chk("R4 ack set", a0 & 32'h0003_0000, 32'h0003_0000);
    wr(CA, 32'h1);
    rd(SA, a0, a1); chk("R4 ack holds", a0 & 32'h0003_0000, 32'h0003_0000);
    wr(CA, 32'h4000_0001);
    rd(SA, a0, a1); chk("R4 ack cleared again", a0 & 32'h0003_0000, 32'd0);
    wr(CA, 32'h1);

    // R7 R9 reset with halt held
    wr(CA, 32'hA000_0001);
    chk("R5 hart reset on", {31'd0, hr0}, 32'd1);
    @(negedge clk); rdone = 1'b1; halted = 1'b1; running = 1'b0;
    @(negedge clk); rdone = 1'b0;
    wr(CA, 32'h8000_0001);
    chk("R5 hart reset off", {31'd0, hr0}, 32'd0);
    rd(SA, a0, a1); chk("R7 R9 havereset and halted", a0 & 32'h000F_0F00, 32'h000C_0300);
    @(negedge clk); rdone = 1'b1;
    wr(CA, 32'h9000_0001);
    @(negedge clk); rdone = 1'b0;
    rd(SA, a0, a1); chk("R7 set wins over ack", a0 & 32'h000C_0000, 32'h000C_0000);
    wr(CA, 32'h1000_0001);
    rd(SA, a0, a1); chk("R7 ack clears", a0 & 32'h000C_0000, 32'd0);

    // R5 R6 fallback to system reset in the reduced build
    wr(CA, 32'h2000_0001);
    rd(CA, a0, a1); chk("R5 unsupported reads 0", a1 & 32'h2000_0000, 32'd0);
    chk("R5 supported reads 1", a0 & 32'h2000_0000, 32'h2000_0000);
    wr(CA, 32'h3);
    chk("R6 sys reset both", {30'd0, sr1, sr0}, 32'd3);
    wr(CA, 32'h1);
    chk("R6 sys reset released", {30'd0, sr1, sr0}, 32'd0);

    // R8 arm, then disarm wins, with system reset
    wr(CA, 32'h9);
    wr(CA, 32'h3);
    chk("R8 armed halt on reset", {30'd0, hq1, hq0}, 32'd1);
    wr(CA, 32'hF);
    chk("R8 disarm wins", {30'd0, hq1, hq0}, 32'd0);
    wr(CA, 32'h1);

    // R12 unmapped and status writes
    wr(CA, 32'h0003_0041);
    wr(SA, 32'hFFFF_FFFF);
    wr(7'h12, 32'hFFFF_FFFF);
    rd(CA, a0, a1); chk("R12 ctrl untouched", a0, 32'h0003_0041);
    rd(7'h12, a0, a1); chk("R12 unmapped reads 0", a0, 32'd0);
    rd(SA, a0, a1); chk("R12 R10 status untouched", a0, exp_stat(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));

    // R2 deactivate clears sticky state
    wr(CA, 32'hC000_0001);
    @(negedge clk); rdone = 1'b1;
    @(negedge clk); rdone = 1'b0;
    wr(CA, 32'h0);
    chk("R2 requests dropped", {28'd0, hq0, rq0, hr0, sr0}, 32'd0);
    rd(SA, a0, a1); chk("R2 sticky cleared", a0 & 32'h000F_0000, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule